// File: doc/BRIEF.md
# Overvoltage Fault Supervisor

This block supervises up to 32 supply-protection channels. Each channel reports a fault flag. The block synchronizes the flag and latches it into a per-channel error bit that stays set until something clears it. From the error bits, the enable state and a per-channel mask, it drives an off/reset line back to each channel's protection hardware. A masked channel is held open: its fault is neither recorded nor acted upon.

A host microcontroller talks to the block over a 6-bit address bus and gets two outputs back:
- a multiplexed data bit that shows one channel's error bit;
- a status bit that is high while any error bit is set.

The top address bit selects the direction. With it low, the lower five bits select a channel to read. With it high, the lower four bits carry a command code and bit 4 acts as a toggle: each change of the toggle runs the command once.

Two shutdown lines complete the interface. One reports that the supply has reached its active state; until then, a parameter-selected set of window-mode channels stays masked. The other clears every error bit.

Top module: `ovs_supervisor`

## Requirements
- R1: With addr_i[5]=0, mux_data_o equals the error bit of channel addr_i[4:0]; it reads 0 for a channel number at or above NUM_CH and whenever addr_i[5]=1.
- R2: status_o is 1 exactly when at least one error bit is set.
- R3: An unmasked fault input is synchronized by two flops and sets its error bit on the third rising clock edge after it changes. The bit stays set after the fault goes away, until a clear.
- R4: A masked channel's fault never sets its error bit, and its chan_off_o line stays 0.
- R5: Command code 5 shifts a 1, and code 4 shifts a 0, into the user mask register. The new bit enters at channel 0 and every other bit moves up one channel.
- R6: While the synchronized shdn_clear_i is high, all error bits are cleared.
- R7: Channels flagged in WIN_CH are masked from reset until shdn_active_i has been seen high. After that they are unmasked for good, until the next reset.
- R8: A write has addr_i[5]=1, the toggle in addr_i[4] and the code in addr_i[3:0]. Code 0 clears every error bit, 1 sets every error bit, 2 enables protection and 3 disables it.
- R9: A command runs once per change of the synchronized toggle bit while in write mode. Holding the address static does not repeat it, and entering write mode does not run it.
- R10: While protection is disabled, all chan_off_o lines are 0, yet faults are still recorded. When protection is enabled, chan_off_o[i] is 1 for a set, unmasked error bit.
- R11: A preset or a clear that lands in the same cycle as an unmasked fault leaves that fault's error bit set.
- R12: After reset, no error bit is set, protection is enabled, the user mask is all zero and the window channels are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_i | input | NUM_CH | Raw per-channel fault flags |
| addr_i | input | 6 | Host address: direction, toggle/channel, code |
| shdn_active_i | input | 1 | Supply has entered the active state |
| shdn_clear_i | input | 1 | Global error clear |
| mux_data_o | output | 1 | Selected channel's error bit |
| status_o | output | 1 | OR of all error bits |
| chan_off_o | output | NUM_CH | Per-channel off/reset drive |

## Verification
Two updates can hit the error register in the same cycle: a host command (preset or clear) and a freshly synchronized fault. The bench provokes each collision by flipping the toggle bit and pulsing a fault on the very same falling edge. Both signals pass through identical two-flop synchronizers, so they reach the register together. After the clear collision, the bench reads the faulting channel back as set while a neighbour reads back as cleared. After the preset collision, it reads the faulting channel back as set.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int ADDR_W = 6;
    localparam int CH_AW  = 5;
    localparam int TGL_B  = 4;
    localparam int DIR_B  = 5;

    typedef enum logic [3:0] {
        OP_CLEAR  = 4'd0,
        OP_PRESET = 4'd1,
        OP_ENABLE = 4'd2,
        OP_DISABL = 4'd3,
        OP_SHIFT0 = 4'd4,
        OP_SHIFT1 = 4'd5
    } op_e;

    typedef struct packed {
        logic clr;
        logic pre;
        logic en;
        logic dis;
        logic shift0;
        logic shift1;
    } op_pulse_t;

endpackage

// File: rtl/ovs_sync.sv
module ovs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stab;
endmodule

// File: rtl/ovs_cmd_decode.sv
module ovs_cmd_decode
    import ovs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    output op_pulse_t         op_o
);
    typedef struct packed {
        logic wr_mode;
        logic tgl_ref;
    } st_t;

    st_t       st_d, st_q;
    logic      exec;
    op_pulse_t op;

    always_comb begin
        st_d = st_q;
        exec = addr_s[DIR_B] && st_q.wr_mode && (addr_s[TGL_B] != st_q.tgl_ref);
        st_d.wr_mode = addr_s[DIR_B];
        if (addr_s[DIR_B]) st_d.tgl_ref = addr_s[TGL_B];
        op = '0;
        if (exec) begin
            case (op_e'(addr_s[3:0]))
                OP_CLEAR:  op.clr    = 1'b1;
                OP_PRESET: op.pre    = 1'b1;
                OP_ENABLE: op.en     = 1'b1;
                OP_DISABL: op.dis    = 1'b1;
                OP_SHIFT0: op.shift0 = 1'b1;
                OP_SHIFT1: op.shift1 = 1'b1;
                default:   op        = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op_o = op;

    // R8: at most one command per cycle
    assert_single_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op))
        else $error("more than one command decoded");

    // R9: after a command the reference tracks the toggle, so it cannot repeat
    assert_toggle_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (st_q.tgl_ref == $past(addr_s[TGL_B])))
        else $error("toggle reference not updated");
endmodule

// File: rtl/ovs_ctrl_regs.sv
module ovs_ctrl_regs
    import ovs_pkg::*;
#(
    parameter int                NUM_CH = 32,
    parameter logic [NUM_CH-1:0] WIN_CH = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_pulse_t         op_i,
    input  logic              active_s,
    output logic              prot_en_o,
    output logic [NUM_CH-1:0] mask_eff_o
);
    typedef struct packed {
        logic              en;
        logic              active;
        logic [NUM_CH-1:0] umask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_i.en)  st_d.en = 1'b1;
        if (op_i.dis) st_d.en = 1'b0;
        if (op_i.shift0 || op_i.shift1)
            st_d.umask = {st_q.umask[NUM_CH-2:0], op_i.shift1};
        st_d.active = st_q.active | active_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.en     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_en_o  = st_q.en;
    assign mask_eff_o = st_q.umask | (WIN_CH & ~{NUM_CH{st_q.active}});

    // R7: once the active state is seen it stays
    assert_active_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |=> st_q.active)
        else $error("active indication lost");

    // R10: a disable command turns protection off
    assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_i.dis |=> !prot_en_o)
        else $error("disable not applied");
endmodule

// File: rtl/ovs_err_bank.sv
module ovs_err_bank #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fault_s,
    input  logic [NUM_CH-1:0] mask_eff,
    input  logic              clr_all,
    input  logic              preset,
    output logic [NUM_CH-1:0] err_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] err;
    } st_t;

    st_t               st_d, st_q;
    logic [NUM_CH-1:0] set_v;

    always_comb begin
        st_d  = st_q;
        set_v = fault_s & ~mask_eff;
        if (clr_all) st_d.err = '0;
        if (preset)  st_d.err = '1;
        st_d.err = st_d.err | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    // R3 / R11: an unmasked fault always lands, whatever else happened
    assert_fault_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.err & $past(set_v)) == $past(set_v)))
        else $error("unmasked fault not latched");

    // R4: a bit rises only from an unmasked fault or a preset
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(preset) |-> ((st_q.err & ~$past(st_q.err) & ~$past(set_v)) == '0))
        else $error("error bit set without cause");

    // R6: a clear leaves only the faults of that cycle
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_all) && !$past(preset)) |-> ((st_q.err & ~$past(set_v)) == '0))
        else $error("clear did not empty the register");

    // R8: preset sets every bit
    assert_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (st_q.err == '1))
        else $error("preset incomplete");
endmodule

// File: rtl/ovs_supervisor.sv
module ovs_supervisor
    import ovs_pkg::*;
#(
    parameter int                NUM_CH = 32,
    parameter logic [NUM_CH-1:0] WIN_CH = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fault_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              shdn_active_i,
    input  logic              shdn_clear_i,
    output logic              mux_data_o,
    output logic              status_o,
    output logic [NUM_CH-1:0] chan_off_o
);
    localparam int PAD_W = 1 << CH_AW;

    logic [NUM_CH-1:0] fault_s;
    logic [ADDR_W-1:0] addr_s;
    logic [1:0]        shdn_s;
    logic [NUM_CH-1:0] mask_eff;
    logic [NUM_CH-1:0] err;
    logic              prot_en;
    op_pulse_t         op;
    logic [PAD_W-1:0]  err_pad;

    ovs_sync #(.W(NUM_CH)) u_fault_sync (
        .clk(clk), .rst_n(rst_n), .async_i(fault_i), .sync_o(fault_s));

    ovs_sync #(.W(ADDR_W)) u_addr_sync (
        .clk(clk), .rst_n(rst_n), .async_i(addr_i), .sync_o(addr_s));

    ovs_sync #(.W(2)) u_shdn_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({shdn_clear_i, shdn_active_i}), .sync_o(shdn_s));

    ovs_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .addr_s(addr_s), .op_o(op));

    ovs_ctrl_regs #(.NUM_CH(NUM_CH), .WIN_CH(WIN_CH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_i(op), .active_s(shdn_s[0]),
        .prot_en_o(prot_en), .mask_eff_o(mask_eff));

    ovs_err_bank #(.NUM_CH(NUM_CH)) u_err (
        .clk(clk), .rst_n(rst_n), .fault_s(fault_s), .mask_eff(mask_eff),
        .clr_all(op.clr | shdn_s[1]), .preset(op.pre), .err_o(err));

    always_comb begin
        err_pad             = '0;
        err_pad[NUM_CH-1:0] = err;
        mux_data_o          = !addr_i[DIR_B] && err_pad[addr_i[CH_AW-1:0]];
    end

    assign status_o = |err;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_off
        assign chan_off_o[i] = err[i] & prot_en & ~mask_eff[i];
    end

    // R10: disabled protection releases every channel line
    assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> (chan_off_o == '0))
        else $error("off line driven while disabled");

    // R2: status follows register contents across a clock
    assert_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err == '0) |-> !status_o)
        else $error("status high with empty register");
endmodule

// File: tb/ovs_supervisor_tb_top.sv
module ovs_supervisor_tb_top;
    localparam int NCH = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] fault = '0;
    logic [5:0]     addr = '0;
    logic           shdn_act = 1'b0;
    logic           shdn_clr = 1'b0;
    logic           mux_data, status;
    logic [NCH-1:0] chan_off;
    logic           tgl = 1'b0;
    int             total = 0;
    int             bad = 0;

    always #2 clk = ~clk;

    ovs_supervisor #(.NUM_CH(NCH), .WIN_CH(32'hF000_0000)) dut_i (
        .clk(clk), .rst_n(rst_n), .fault_i(fault), .addr_i(addr),
        .shdn_active_i(shdn_act), .shdn_clear_i(shdn_clr),
        .mux_data_o(mux_data), .status_o(status), .chan_off_o(chan_off));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [3:0] code);
        @(negedge clk);
        addr = {1'b1, tgl, code};
        settle();
        tgl = ~tgl;
        addr = {1'b1, tgl, code};
        settle();
    endtask

    task automatic read_ch(input int ch, output logic v);
        @(negedge clk);
        addr = {1'b0, 5'(ch)};
        @(negedge clk);
        v = mux_data;
    endtask

    task automatic pulse_fault(input int ch);
        @(negedge clk);
        fault[ch] = 1'b1;
        @(negedge clk);
        fault[ch] = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        logic v;
        check("R12 status after reset", 32'(status), 0);
        check("R12 off lines after reset", chan_off, 0);
        read_ch(0, v);
        check("R12 ch0 read after reset", 32'(v), 0);
    endtask

    task automatic t_window();
        logic v;
        pulse_fault(30);
        read_ch(30, v);
        check("R7 window ch30 masked before active", 32'(v), 0);
        check("R4 masked ch30 off line", 32'(chan_off[30]), 0);
        @(negedge clk); shdn_act = 1'b1;
        settle();
        shdn_act = 1'b0;
        settle();
        pulse_fault(30);
        read_ch(30, v);
        check("R7 window ch30 live after active", 32'(v), 1);
        check("R2 status with one error", 32'(status), 1);
        check("R10 off line ch30 enabled", 32'(chan_off[30]), 1);
    endtask

    task automatic t_clear_once();
        send_cmd(4'd0);
        check("R8 clear command", 32'(status), 0);
        pulse_fault(2);
        repeat (20) @(negedge clk);
        check("R9 held address does not repeat clear", 32'(status), 1);
        check("R3 fault is sticky", 32'(chan_off[2]), 1);
    endtask

    task automatic t_read();
        logic v;
        pulse_fault(7);
        read_ch(2, v);  check("R1 read ch2 set", 32'(v), 1);
        read_ch(3, v);  check("R1 read ch3 clear", 32'(v), 0);
        read_ch(7, v);  check("R3 one-cycle fault latched ch7", 32'(v), 1);
        read_ch(31, v); check("R1 read ch31 clear", 32'(v), 0);
        @(negedge clk); addr = 6'h22;
        @(negedge clk); check("R1 write mode reads zero", 32'(mux_data), 0);
    endtask

    task automatic t_shdn_clear();
        @(negedge clk); shdn_clr = 1'b1;
        @(negedge clk); @(negedge clk); shdn_clr = 1'b0;
        settle();
        check("R6 global clear", 32'(status), 0);
    endtask

    task automatic t_preset();
        logic v;
        send_cmd(4'd1);
        read_ch(0, v);  check("R8 preset ch0", 32'(v), 1);
        read_ch(31, v); check("R8 preset ch31", 32'(v), 1);
        send_cmd(4'd0);
        check("R8 clear after preset", 32'(status), 0);
    endtask

    task automatic t_disable();
        logic v;
        pulse_fault(5);
        check("R10 off ch5 while enabled", 32'(chan_off[5]), 1);
        send_cmd(4'd3);
        check("R10 off lines idle while disabled", chan_off, 0);
        pulse_fault(9);
        read_ch(9, v);
        check("R10 fault recorded while disabled", 32'(v), 1);
        send_cmd(4'd2);
        check("R10 off ch9 after enable", 32'(chan_off[9]), 1);
        send_cmd(4'd0);
    endtask

    task automatic t_mask();
        logic v;
        send_cmd(4'd5);
        pulse_fault(0);
        read_ch(0, v); check("R5 shift-in 1 masks ch0", 32'(v), 0);
        send_cmd(4'd4);
        pulse_fault(1);
        read_ch(1, v); check("R5 mask moved to ch1", 32'(v), 0);
        pulse_fault(0);
        read_ch(0, v); check("R5 ch0 unmasked after shift", 32'(v), 1);
        check("R4 masked ch1 off line", 32'(chan_off[1]), 0);
        send_cmd(4'd0);
    endtask

    task automatic t_conflict();
        logic v;
        @(negedge clk); addr = {1'b1, tgl, 4'd1};
        settle();
        tgl = ~tgl; addr = {1'b1, tgl, 4'd1}; fault[20] = 1'b1;
        @(negedge clk); fault[20] = 1'b0;
        settle();
        read_ch(20, v); check("R11 preset with fault ch20", 32'(v), 1);
        @(negedge clk); addr = {1'b1, tgl, 4'd0};
        settle();
        tgl = ~tgl; addr = {1'b1, tgl, 4'd0}; fault[21] = 1'b1;
        @(negedge clk); fault[21] = 1'b0;
        settle();
        read_ch(21, v); check("R11 fault ch21 wins over clear", 32'(v), 1);
        read_ch(20, v); check("R11 ch20 cleared by clear", 32'(v), 0);
        read_ch(22, v); check("R11 ch22 cleared by clear", 32'(v), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_window();
        t_clear_once();
        t_read();
        t_shdn_clear();
        t_preset();
        t_disable();
        t_mask();
        t_conflict();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule